// File: doc/BRIEF.md
# Strobed Latch Bridge to Byte-Wide SRAM

This block connects a narrow host port to a byte-wide static RAM with a 19-bit address. The host has an 8-bit data path, a 3-bit select field and an active-low gate strobe. The host builds the RAM address one byte at a time by steering its data byte into one of three address latches. It then opens a gate window with a read or write select to move a byte to or from the RAM.

All host inputs are sampled on the block clock. Decoding is combinational and qualified by the gate. Read and write enables, and the data drive enables in both directions, are active only while the gate is low. Outside a window, the host-side and RAM-side data drivers are off, so other devices can use the shared bus.

The block also has two one-cycle pulse outputs for verification. The first flags a gate window shorter than a configurable minimum; a write window needs one cycle more than that minimum. The second flags a window opened with a select code that is not used.

Top module: `sram_latch_bridge`

## Requirements
- R1: After reset, ram_addr_o is 0, spare_o is 0, ram_oe_n_o and ram_we_n_o are 1, both data drive enables are 0, and both pulse outputs are 0.
- R2: While gate_n_i is 1, ram_oe_n_o and ram_we_n_o stay 1, host_data_oe_o and ram_data_oe_o stay 0, and no latch loads whatever sel_i and host_data_i hold.
- R3: With gate_n_i 0 and sel_i = 0 (read), ram_oe_n_o is 0, host_data_oe_o is 1 and host_data_o equals ram_data_i.
- R4: With gate_n_i 0 and sel_i = 1 (write), ram_we_n_o is 0, ram_data_oe_o is 1 and ram_data_o equals host_data_i.
- R5: A clock edge with gate_n_i 0 and sel_i = 2 loads host_data_i into ram_addr_o[7:0]. A clock edge with gate_n_i 0 and sel_i = 3 loads host_data_i into ram_addr_o[15:8].
- R6: A clock edge with gate_n_i 0 and sel_i = 4 loads host_data_i[2:0] into ram_addr_o[18:16] and host_data_i[3] into spare_o.
- R7: Select codes 5, 6 and 7 load nothing and assert no enable. Opening a gate window with one of these codes makes illegal_o 1 for exactly the cycle after the first low-sampled edge.
- R8: Let N be the number of clock edges that sample gate_n_i low in a window. On the edge that first samples it high again, width_err_o pulses for one cycle if N < MIN_LOW_CYC, or if the last select in the window was write and N < MIN_LOW_CYC+1.
- R9: host_data_oe_o and ram_data_oe_o are never 1 together. host_data_oe_o is 1 only for a read select with gate_n_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_n_i | input | 1 | Host gate strobe, active low |
| sel_i | input | 3 | Host select code |
| host_data_i | input | 8 | Byte driven by the host |
| host_data_o | output | 8 | Byte returned to the host on reads |
| host_data_oe_o | output | 1 | Drive enable toward the host |
| ram_addr_o | output | 19 | RAM address from the three latches |
| ram_data_i | input | 8 | Byte driven by the RAM |
| ram_data_o | output | 8 | Byte driven to the RAM on writes |
| ram_data_oe_o | output | 1 | Drive enable toward the RAM |
| ram_oe_n_o | output | 1 | RAM read enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| spare_o | output | 1 | Spare indicator from high latch bit 3 |
| illegal_o | output | 1 | One-cycle pulse for an unused select code |
| width_err_o | output | 1 | One-cycle pulse for a gate window that is too short |

## Verification
The bench holds latch selects and data steady while the gate is high. A design that ignored the gate would load the address at that point. It runs write windows of exactly the base minimum width, which a checker without the extra write cycle would accept, and it runs read windows one cycle below the minimum. Unused select codes are sent with all-ones data, so a decoder that aliased them onto a latch or an enable would show a changed address or an active strobe. The bench also checks that the two data drive enables are never high at once, and reads back RAM data that depends on the address to confirm the exact latch bit positions.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_RD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_WR  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MID = 3'd3;
  localparam logic [SEL_W-1:0] SEL_HI  = 3'd4;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [2:0] ld;   // {hi, mid, lo}
    logic       bad;
  } dec_t;
endpackage

// File: rtl/sel_decoder.sv
module sel_decoder
  import sram_bridge_pkg::*;
(
  input  logic             gate_n_i,
  input  logic [SEL_W-1:0] sel_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '0;
    if (!gate_n_i) begin
      unique case (sel_i)
        SEL_RD:  dec_o.rd    = 1'b1;
        SEL_WR:  dec_o.wr    = 1'b1;
        SEL_LO:  dec_o.ld[0] = 1'b1;
        SEL_MID: dec_o.ld[1] = 1'b1;
        SEL_HI:  dec_o.ld[2] = 1'b1;
        default: dec_o.bad   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/strobe_monitor.sv
module strobe_monitor #(
  parameter int MIN_LOW_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_n_i,
  input  logic is_wr_i,
  input  logic is_bad_i,
  output logic illegal_o,
  output logic width_err_o
);
  localparam int SAT   = MIN_LOW_CYC + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic             gate_q;
  logic             wr_q;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] need;
  logic             fall, rise;

  assign fall = !gate_n_i && gate_q;
  assign rise = gate_n_i && !gate_q;
  assign need = wr_q ? CNT_W'(SAT) : CNT_W'(MIN_LOW_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q      <= 1'b1;
      wr_q        <= 1'b0;
      low_cnt     <= '0;
      illegal_o   <= 1'b0;
      width_err_o <= 1'b0;
    end else begin
      gate_q      <= gate_n_i;
      illegal_o   <= fall && is_bad_i;
      width_err_o <= rise && (low_cnt < need);
      if (gate_n_i) begin
        low_cnt <= '0;
        wr_q    <= 1'b0;
      end else begin
        wr_q <= is_wr_i;
        if (low_cnt < CNT_W'(SAT)) low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R7
  illegal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
  // R8
  width_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_err_o |-> $past(gate_n_i));
endmodule

// File: rtl/sram_latch_bridge.sv
module sram_latch_bridge
  import sram_bridge_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 19,
  parameter int MIN_LOW_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_n_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_data_i,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              ram_data_oe_o,
  output logic              ram_oe_n_o,
  output logic              ram_we_n_o,
  output logic              spare_o,
  output logic              illegal_o,
  output logic              width_err_o
);
  localparam int N_BYTES = 2;
  localparam int HI_W    = ADDR_W - N_BYTES * DATA_W;

  dec_t              dec;
  logic [HI_W:0]     hi_q;
  logic [DATA_W-1:0] byte_q [N_BYTES];

  sel_decoder i_dec (
    .gate_n_i (gate_n_i),
    .sel_i    (sel_i),
    .dec_o    (dec)
  );

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    addr_latch #(.W(DATA_W)) i_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (dec.ld[g]),
      .d_i    (host_data_i),
      .q_o    (byte_q[g])
    );
  end

  addr_latch #(.W(HI_W + 1)) i_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (dec.ld[N_BYTES]),
    .d_i    (host_data_i[HI_W:0]),
    .q_o    (hi_q)
  );

  strobe_monitor #(.MIN_LOW_CYC(MIN_LOW_CYC)) i_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_n_i    (gate_n_i),
    .is_wr_i     (dec.wr),
    .is_bad_i    (dec.bad),
    .illegal_o   (illegal_o),
    .width_err_o (width_err_o)
  );

  assign ram_addr_o     = {hi_q[HI_W-1:0], byte_q[1], byte_q[0]};
  assign spare_o        = hi_q[HI_W];
  assign ram_oe_n_o     = !dec.rd;
  assign ram_we_n_o     = !dec.wr;
  assign host_data_o    = ram_data_i;
  assign host_data_oe_o = dec.rd;
  assign ram_data_o     = host_data_i;
  assign ram_data_oe_o  = dec.wr;

  // R2
  gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_n_i |-> (ram_oe_n_o && ram_we_n_o && !host_data_oe_o && !ram_data_oe_o));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_n_i |=> ($stable(ram_addr_o) && $stable(spare_o)));
  // R7
  bad_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_n_i && sel_i > SEL_HI) |=> ($stable(ram_addr_o) && $stable(spare_o)));
  // R9
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_data_oe_o && ram_data_oe_o));
  // R9
  host_drive_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_data_oe_o |-> (!gate_n_i && sel_i == SEL_RD && !ram_oe_n_o));
endmodule

// File: tb/test_sram_latch_bridge.sv
module test_sram_latch_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_n = 1'b1;
  logic [2:0]  sel = 3'd0;
  logic [7:0]  hdat = 8'd0;
  logic [7:0]  hdat_o;
  logic        hoe;
  logic [18:0] addr;
  logic [7:0]  rdat;
  logic [7:0]  rdat_o;
  logic        roe;
  logic        oe_n, we_n, spare, illegal, werr;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // RAM model: data depends on every address bit
  assign rdat = addr[7:0] ^ addr[15:8] ^ {5'b0, addr[18:16]};

  sram_latch_bridge i_sram_latch_bridge (
    .clk_i (clk), .rst_ni (rst_n), .gate_n_i (gate_n), .sel_i (sel),
    .host_data_i (hdat), .host_data_o (hdat_o), .host_data_oe_o (hoe),
    .ram_addr_o (addr), .ram_data_i (rdat), .ram_data_o (rdat_o),
    .ram_data_oe_o (roe), .ram_oe_n_o (oe_n), .ram_we_n_o (we_n),
    .spare_o (spare), .illegal_o (illegal), .width_err_o (werr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic open_win(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; hdat = d; gate_n = 1'b0;
    #1;
  endtask

  // finish a window with n low-sampled edges, return width_err seen after rise
  task automatic close_win(input int n, output logic we);
    repeat (n) @(posedge clk);
    @(negedge clk);
    gate_n = 1'b1;
    @(posedge clk); #1;
    we = werr;
  endtask

  task automatic load(input logic [2:0] s, input logic [7:0] d);
    logic we;
    open_win(s, d);
    close_win(2, we);
    check("R8 no err on legal width", {31'd0, we}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 addr", {13'd0, addr}, 32'd0);
    check("R1 spare", {31'd0, spare}, 32'd0);
    check("R1 strobes", {30'd0, oe_n, we_n}, 32'd3);
    check("R1 drives", {30'd0, hoe, roe}, 32'd0);
    check("R1 pulses", {30'd0, illegal, werr}, 32'd0);
  endtask

  task automatic t_addr_load;
    load(3'd2, 8'h7C);
    check("R5 low byte", {13'd0, addr}, 32'h0007C);
    load(3'd3, 8'hA3);
    check("R5 mid byte", {13'd0, addr}, 32'h0A37C);
    load(3'd4, 8'hFD);
    check("R6 high bits", {13'd0, addr}, 32'h5A37C);
    check("R6 spare on", {31'd0, spare}, 32'd1);
  endtask

  task automatic t_gate_high;
    @(negedge clk);
    sel = 3'd2; hdat = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check("R2 no load lo", {13'd0, addr}, 32'h5A37C);
    check("R2 strobes idle", {30'd0, oe_n, we_n}, 32'd3);
    @(negedge clk); sel = 3'd0;
    repeat (2) @(posedge clk); #1;
    check("R2 rd sel no strobe", {30'd0, oe_n, hoe}, 32'd2);
    @(negedge clk); sel = 3'd1;
    repeat (2) @(posedge clk); #1;
    check("R2 wr sel no strobe", {30'd0, we_n, roe}, 32'd2);
    @(negedge clk); sel = 3'd4; hdat = 8'h00;
    repeat (2) @(posedge clk); #1;
    check("R2 no load hi", {31'd0, spare}, 32'd1);
  endtask

  task automatic t_read;
    logic we;
    open_win(3'd0, 8'h00);
    check("R3 oe_n low", {31'd0, oe_n}, 32'd0);
    check("R3 host drive", {31'd0, hoe}, 32'd1);
    check("R3 read data", {24'd0, hdat_o}, 32'h000000DA);
    check("R9 no ram drive on read", {30'd0, roe, we_n}, 32'd1);
    close_win(2, we);
    check("R8 read at min", {31'd0, we}, 32'd0);
    check("R3 oe_n released", {30'd0, oe_n, hoe}, 32'd2);
  endtask

  task automatic t_write;
    logic we;
    open_win(3'd1, 8'h3C);
    check("R4 we_n low", {31'd0, we_n}, 32'd0);
    check("R4 ram drive", {31'd0, roe}, 32'd1);
    check("R4 write data", {24'd0, rdat_o}, 32'h3C);
    check("R9 no host drive on write", {30'd0, hoe, oe_n}, 32'd1);
    close_win(3, we);
    check("R8 write min+1", {31'd0, we}, 32'd0);
    open_win(3'd1, 8'hC3);
    close_win(2, we);
    check("R8 write at base min", {31'd0, we}, 32'd1);
    @(posedge clk); #1;
    check("R8 pulse one cycle", {31'd0, werr}, 32'd0);
    open_win(3'd0, 8'h00);
    close_win(1, we);
    check("R8 short read", {31'd0, we}, 32'd1);
    open_win(3'd2, 8'h7C);
    close_win(1, we);
    check("R8 short latch load", {31'd0, we}, 32'd1);
  endtask

  task automatic t_illegal;
    for (int s = 5; s < 8; s++) begin
      logic we;
      open_win(3'(s), 8'hFF);
      check("R7 no strobes", {30'd0, oe_n, we_n}, 32'd3);
      check("R7 no drives", {30'd0, hoe, roe}, 32'd0);
      check("R7 no early pulse", {31'd0, illegal}, 32'd0);
      @(posedge clk); #1;
      check("R7 pulse", {31'd0, illegal}, 32'd1);
      @(posedge clk); #1;
      check("R7 pulse ends", {31'd0, illegal}, 32'd0);
      @(negedge clk); gate_n = 1'b1;
      @(posedge clk); #1;
      we = werr;
      check("R7 addr untouched", {13'd0, addr}, 32'h5A37C);
      check("R7 spare untouched", {31'd0, spare}, 32'd1);
    end
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 1'b0;
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_addr_load();
    t_gate_high();
    t_read();
    t_write();
    t_illegal();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule